// File: doc/BRIEF.md
# Pipelined Flash Command Controller

This block sits in front of an embedded flash array and turns register writes from a host bus into timed program, erase and erase-verify operations. The host stages an address and a data word. It then writes a command code. The command joins a two-slot queue: one slot executes and the other waits. This lets software load the next operation while the current one is still running. The operations are timed by a slow tick. A programmable divider derives that tick from the system clock. The divider must be written, once, before any command is taken.

A high-voltage enable rises before each program or erase and is held through a ramp period. The enable stays up between two queued program commands that fall in the same row, so the second command skips the ramp. Two flags report progress: one shows that the waiting slot is free, and one shows that nothing is left to run. Each flag drives its own interrupt output, which is gated by an enable bit. Commands that arrive at a bad time are refused and latch an error flag. The array and the pump are reduced to level strobes that last a fixed number of ticks, plus a blank-check input that the verify command samples.

Register map, as word offsets on `reg_addr`:
- 0: divider. Bits [DIV_W-1:0] hold the divisor D, and bit 15 is the lock.
- 1: interrupt enables. Bit 0 covers slot-free and bit 1 covers all-done.
- 2: status. Bit 0 is slot free, bit 1 is all done, bit 2 is the write-one-to-clear error and bit 3 is verify fail.
- 3: staged address.
- 4: staged data.
- 5: command, write only. Code 1 is program, 2 is erase and 3 is erase-verify.
- 6 and 7: unused.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, offset 0 reads 0. The first write to it stores bits [DIV_W-1:0] as D and sets the lock, read back at bit 15. Later writes to offset 0 leave both fields unchanged until the next reset.
- R2: Some command writes are refused, and a refused command never runs. A command is refused if it arrives while the lock is clear, while the waiting slot is occupied, or with code 0. A refusal sets status bit 2. Writing 1 to status bit 2 clears it.
- R3: The queue holds one executing command and one waiting command. Status bit 0 is 0 exactly while the waiting slot is occupied. Commands run in the order they were written.
- R4: Status bit 1 is 1 exactly when no command is executing or waiting. It reads 1 after reset.
- R5: `irq_empty` equals (enable bit 0 AND status bit 0), registered one cycle later. `irq_done` equals (enable bit 1 AND status bit 1), also registered one cycle later.
- R6: The operation tick recurs every D+1 clocks while an operation is in progress. `arr_pgm` stays high for exactly PROG_TICKS*(D+1) clocks per program. `arr_ers` stays high for exactly ERASE_TICKS*(D+1) clocks per erase. At most one strobe is high at a time.
- R7: A program or erase that starts with `hv_en` low first raises `hv_en` for RAMP_TICKS*(D+1) clocks with no strobe. `arr_pgm` and `arr_ers` are only ever high while `hv_en` is high.
- R8: Sometimes a program completes while the waiting slot holds another program with the same row, where the row is address bits [ADDR_W-1:COL_W]. In that case `hv_en` stays high with no ramp. In every other case, `hv_en` falls when the operation completes.
- R9: Erase-verify raises `arr_vfy` for VERIFY_TICKS*(D+1) clocks with `hv_en` low. At the end it sets status bit 3 to the inverse of `blank_ok`.
- R10: Offsets 6 and 7 read 0, and writes to them change no other register.
- R11: While a command executes, `arr_addr` and `arr_wdata` carry that command's staged address and data, even if the staging registers are rewritten in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for the offset on the previous cycle |
| irq_empty | output | 1 | Waiting-slot-free interrupt |
| irq_done | output | 1 | All-operations-done interrupt |
| hv_en | output | 1 | High-voltage generator enable |
| arr_pgm | output | 1 | Array program strobe |
| arr_ers | output | 1 | Array erase strobe |
| arr_vfy | output | 1 | Array blank-check strobe |
| arr_addr | output | ADDR_W | Address of the executing command |
| arr_wdata | output | DATA_W | Data of the executing command |
| blank_ok | input | 1 | Blank-check result from the array |

## Verification
The assertions check on every cycle the properties that hold regardless of scenario:
- the lock and the divisor stay put once the divider is written;
- an early command latches the error flag;
- the queue never pushes into an occupied slot or pops an empty one;
- strobes are mutually exclusive;
- program and erase run only under high voltage, and verify never does;
- high voltage drops after any operation other than a program.

Only the bench scenarios can show the exact strobe and ramp lengths, and it sweeps them across several divisor values. The same applies to whether the voltage bridges a same-row program pair, and to the refusal of a third command. The verify result and the interrupt masking are also shown only by the bench.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_ERASE  = 2'd2,
    OP_VERIFY = 2'd3
  } op_e;

  localparam int RA_DIV  = 0;
  localparam int RA_CTRL = 1;
  localparam int RA_STAT = 2;
  localparam int RA_ADDR = 3;
  localparam int RA_DATA = 4;
  localparam int RA_CMD  = 5;
endpackage

// File: rtl/fc_timebase.sv
module fc_timebase #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // phase restarts whenever the sequencer is idle, so every phase is whole ticks
  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fc_cmd_queue.sv
module fc_cmd_queue #(
  parameter int ENT_W = 30,
  parameter int HDR_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic             pop,
  output logic             act_valid,
  output logic [ENT_W-1:0] act_ent,
  output logic             buf_valid,
  output logic [HDR_W-1:0] buf_hdr
);
  logic [ENT_W-1:0] buf_q;

  assign buf_hdr = buf_q[ENT_W-1 -: HDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      buf_valid <= 1'b0;
    end else if (pop) begin
      if (buf_valid) buf_valid <= 1'b0;
      else           act_valid <= push;
    end else if (push) begin
      if (!act_valid) act_valid <= 1'b1;
      else            buf_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      if (buf_valid)  act_ent <= buf_q;
      else if (push)  act_ent <= push_ent;
    end else if (push) begin
      if (!act_valid) act_ent <= push_ent;
      else            buf_q   <= push_ent;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) push |-> !buf_valid); // R3
  AST_POP_HAS_ACT:  assert property (@(posedge clk) disable iff (rst) pop |-> act_valid);   // R3
endmodule

// File: rtl/fc_sequencer.sv
module fc_sequencer
  import flash_cmd_pkg::*;
#(
  parameter int ROW_W        = 7,
  parameter int PROG_TICKS   = 6,
  parameter int ERASE_TICKS  = 200,
  parameter int VERIFY_TICKS = 4,
  parameter int RAMP_TICKS   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             act_valid,
  input  logic [1:0]       act_op,
  input  logic [ROW_W-1:0] act_row,
  input  logic             buf_valid,
  input  logic [1:0]       buf_op,
  input  logic [ROW_W-1:0] buf_row,
  input  logic             blank_ok,
  output logic             run,
  output logic             pop,
  output logic             hv_en,
  output logic             arr_pgm,
  output logic             arr_ers,
  output logic             arr_vfy,
  output logic             vfail
);
  localparam int MAX_A = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
  localparam int MAX_B = (VERIFY_TICKS > RAMP_TICKS) ? VERIFY_TICKS : RAMP_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);

  typedef enum logic [1:0] {S_IDLE, S_RAMP, S_RUN} st_e;
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q, dur;
  logic             needs_hv, keep_hv;

  always_comb begin
    case (act_op)
      OP_PROG:  dur = CNT_W'(PROG_TICKS - 1);
      OP_ERASE: dur = CNT_W'(ERASE_TICKS - 1);
      default:  dur = CNT_W'(VERIFY_TICKS - 1);
    endcase
  end

  assign needs_hv = (act_op == OP_PROG) || (act_op == OP_ERASE);
  assign keep_hv  = (act_op == OP_PROG) && buf_valid && (buf_op == OP_PROG) && (buf_row == act_row);
  assign run      = (st_q != S_IDLE);
  assign pop      = (st_q == S_RUN) && tick && (cnt_q == dur);
  assign arr_pgm  = (st_q == S_RUN) && (act_op == OP_PROG);
  assign arr_ers  = (st_q == S_RUN) && (act_op == OP_ERASE);
  assign arr_vfy  = (st_q == S_RUN) && (act_op == OP_VERIFY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      hv_en <= 1'b0;
      vfail <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (act_valid) begin
            if (needs_hv && !hv_en) begin
              st_q  <= S_RAMP;
              hv_en <= 1'b1;
            end else begin
              st_q <= S_RUN;
            end
          end
        end
        S_RAMP: if (tick) begin
          if (cnt_q == CNT_W'(RAMP_TICKS - 1)) begin
            cnt_q <= '0;
            st_q  <= S_RUN;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: if (tick) begin
          if (cnt_q == dur) begin
            cnt_q <= '0;
            st_q  <= S_IDLE;
            hv_en <= keep_hv;
            if (act_op == OP_VERIFY) vfail <= !blank_ok;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  AST_STROBE_EXCL:   assert property (@(posedge clk) disable iff (rst) $onehot0({arr_pgm, arr_ers, arr_vfy})); // R6
  AST_WRITE_HAS_HV:  assert property (@(posedge clk) disable iff (rst) (arr_pgm || arr_ers) |-> hv_en);         // R7
  AST_VERIFY_NO_HV:  assert property (@(posedge clk) disable iff (rst) arr_vfy |-> !hv_en);                      // R9
  AST_HV_DROP_OTHER: assert property (@(posedge clk) disable iff (rst) (pop && act_op != OP_PROG) |=> !hv_en);   // R8
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_cmd_pkg::*;
#(
  parameter int RA_W         = 3,
  parameter int DIV_W        = 6,
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 16,
  parameter int COL_W        = 5,
  parameter int PROG_TICKS   = 6,
  parameter int ERASE_TICKS  = 200,
  parameter int VERIFY_TICKS = 4,
  parameter int RAMP_TICKS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_empty,
  output logic              irq_done,
  output logic              hv_en,
  output logic              arr_pgm,
  output logic              arr_ers,
  output logic              arr_vfy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic              blank_ok
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int HDR_W = 2 + ROW_W;
  localparam int ENT_W = 2 + ADDR_W + DATA_W;

  logic [DIV_W-1:0]  div_q;
  logic              locked_q, aerr_q;
  logic [1:0]        ien_q;
  logic [ADDR_W-1:0] stage_addr;
  logic [DATA_W-1:0] stage_data, rd_nxt;
  logic              cmd_wr, push, pop, run, tick, vfail;
  logic              act_valid, buf_valid, buf_empty, complete;
  logic [ENT_W-1:0]  act_ent;
  logic [HDR_W-1:0]  buf_hdr;

  assign cmd_wr    = reg_wr && (reg_addr == RA_W'(RA_CMD));
  assign push      = cmd_wr && locked_q && !buf_valid && (reg_wdata[1:0] != OP_NONE);
  assign buf_empty = !buf_valid;
  assign complete  = !act_valid && !buf_valid;
  assign arr_addr  = act_ent[DATA_W +: ADDR_W];
  assign arr_wdata = act_ent[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      locked_q   <= 1'b0;
      ien_q      <= '0;
      aerr_q     <= 1'b0;
      stage_addr <= '0;
      stage_data <= '0;
      irq_empty  <= 1'b0;
      irq_done   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_W'(RA_DIV) && !locked_q) begin
        div_q    <= reg_wdata[DIV_W-1:0];
        locked_q <= 1'b1;
      end
      if (reg_wr && reg_addr == RA_W'(RA_CTRL)) ien_q      <= reg_wdata[1:0];
      if (reg_wr && reg_addr == RA_W'(RA_ADDR)) stage_addr <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && reg_addr == RA_W'(RA_DATA)) stage_data <= reg_wdata;
      if (cmd_wr && !push)                                          aerr_q <= 1'b1;
      else if (reg_wr && reg_addr == RA_W'(RA_STAT) && reg_wdata[2]) aerr_q <= 1'b0;
      irq_empty <= ien_q[0] && buf_empty;
      irq_done  <= ien_q[1] && complete;
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (reg_addr)
      RA_W'(RA_DIV): begin
        rd_nxt[DIV_W-1:0]  = div_q;
        rd_nxt[DATA_W-1]   = locked_q;
      end
      RA_W'(RA_CTRL): rd_nxt[1:0]        = ien_q;
      RA_W'(RA_STAT): rd_nxt[3:0]        = {vfail, aerr_q, complete, buf_empty};
      RA_W'(RA_ADDR): rd_nxt[ADDR_W-1:0] = stage_addr;
      RA_W'(RA_DATA): rd_nxt             = stage_data;
      default:        rd_nxt             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  fc_timebase #(.DIV_W(DIV_W)) tb_i (
    .clk(clk), .rst(rst), .run(run), .div(div_q), .tick(tick)
  );

  fc_cmd_queue #(.ENT_W(ENT_W), .HDR_W(HDR_W)) q_i (
    .clk(clk), .rst(rst), .push(push),
    .push_ent({reg_wdata[1:0], stage_addr, stage_data}),
    .pop(pop), .act_valid(act_valid), .act_ent(act_ent),
    .buf_valid(buf_valid), .buf_hdr(buf_hdr)
  );

  fc_sequencer #(
    .ROW_W(ROW_W), .PROG_TICKS(PROG_TICKS), .ERASE_TICKS(ERASE_TICKS),
    .VERIFY_TICKS(VERIFY_TICKS), .RAMP_TICKS(RAMP_TICKS)
  ) seq_i (
    .clk(clk), .rst(rst), .tick(tick),
    .act_valid(act_valid), .act_op(act_ent[ENT_W-1 -: 2]),
    .act_row(act_ent[ENT_W-3 -: ROW_W]),
    .buf_valid(buf_valid), .buf_op(buf_hdr[HDR_W-1 -: 2]),
    .buf_row(buf_hdr[ROW_W-1:0]), .blank_ok(blank_ok),
    .run(run), .pop(pop), .hv_en(hv_en),
    .arr_pgm(arr_pgm), .arr_ers(arr_ers), .arr_vfy(arr_vfy), .vfail(vfail)
  );

  AST_LOCK_HOLD:     assert property (@(posedge clk) disable iff (rst) locked_q |=> locked_q);         // R1
  AST_DIV_FROZEN:    assert property (@(posedge clk) disable iff (rst) locked_q |=> $stable(div_q));   // R1
  AST_EARLY_CMD_ERR: assert property (@(posedge clk) disable iff (rst) (cmd_wr && !locked_q) |=> aerr_q); // R2
  AST_FULL_CMD_ERR:  assert property (@(posedge clk) disable iff (rst) (cmd_wr && buf_valid) |=> aerr_q);  // R2
endmodule

// File: tb/flash_cmd_frontend_tb_top.sv
module flash_cmd_frontend_tb_top;
  localparam int RA_W = 3, DIV_W = 6, ADDR_W = 12, DATA_W = 16, COL_W = 5;
  localparam int P = 3, E = 5, V = 2, R = 2;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, blank_ok = 1'b1;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata, arr_wdata;
  logic [ADDR_W-1:0] arr_addr;
  logic irq_empty, irq_done, hv_en, arr_pgm, arr_ers, arr_vfy;

  int errors = 0, checks = 0;
  int pgm_run = 0, pgm_len = 0, pgm_rise = 0, ers_run = 0, ers_len = 0;
  int vfy_run = 0, vfy_len = 0, vfy_rise = 0, hv_run = 0, hv_len = 0, hv_rise = 0;
  logic pgm_d = 0, ers_d = 0, vfy_d = 0, hv_d = 0;
  int pgm_addr = 0, pgm_data = 0;

  always #5 clk = ~clk;

  flash_cmd_frontend #(
    .RA_W(RA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W),
    .PROG_TICKS(P), .ERASE_TICKS(E), .VERIFY_TICKS(V), .RAMP_TICKS(R)
  ) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_empty(irq_empty), .irq_done(irq_done), .hv_en(hv_en),
    .arr_pgm(arr_pgm), .arr_ers(arr_ers), .arr_vfy(arr_vfy), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .blank_ok(blank_ok)
  );

  always @(negedge clk) begin
    if (arr_pgm) begin
      if (!pgm_d) begin pgm_rise++; pgm_run = 0; pgm_addr = int'(arr_addr); pgm_data = int'(arr_wdata); end
      pgm_run++;
    end else if (pgm_d) pgm_len = pgm_run;
    if (arr_ers) begin if (!ers_d) ers_run = 0; ers_run++; end
    else if (ers_d) ers_len = ers_run;
    if (arr_vfy) begin if (!vfy_d) begin vfy_rise++; vfy_run = 0; end vfy_run++; end
    else if (vfy_d) vfy_len = vfy_run;
    if (hv_en) begin if (!hv_d) begin hv_rise++; hv_run = 0; end hv_run++; end
    else if (hv_d) hv_len = hv_run;
    pgm_d = arr_pgm; ers_d = arr_ers; vfy_d = arr_vfy; hv_d = hv_en;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[RA_W-1:0]; reg_wdata = d[DATA_W-1:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = a[RA_W-1:0];
    @(posedge clk);
    #1 v = int'(reg_rdata);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wait_done();
    int v;
    for (int i = 0; i < 3000; i++) begin
      rd(2, v);
      if (v[1]) break;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(1_500_000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v, h0, p0;
    do_reset();
    rd(0, v);  chk("R1 reset divider", v, 0);
    rd(2, v);  chk("R4 R3 reset status", v, 3);
    chk("R5 reset irq", {30'd0, irq_empty, irq_done}, 0);

    // command with no divider configured
    wr(5, 1);
    rd(2, v);  chk("R2 early cmd error", v & 7, 7);
    repeat (20) @(negedge clk);
    chk("R2 early cmd not run", pgm_rise, 0);
    wr(2, 4);
    rd(2, v);  chk("R2 w1c clear", (v >> 2) & 1, 0);

    for (int d = 0; d < 4; d++) begin
      do_reset();
      wr(0, d);
      rd(0, v);  chk("R1 divider lock", v, 32'h8000 | d);
      wr(0, d + 5);
      rd(0, v);  chk("R1 divider write-once", v, 32'h8000 | d);
      wr(3, 12'h040 + d); wr(4, 16'hA500 + d); wr(5, 1);
      wait_done();
      chk("R6 program length", pgm_len, P * (d + 1));
      chk("R7 program hv span", hv_len, (R + P) * (d + 1));
      chk("R11 program addr", pgm_addr, 12'h040 + d);
      chk("R11 program data", pgm_data, 16'hA500 + d);
      wr(5, 2);
      wait_done();
      chk("R6 erase length", ers_len, E * (d + 1));
      chk("R7 erase hv span", hv_len, (R + E) * (d + 1));
      h0 = hv_rise;
      blank_ok = 1'b0;
      wr(5, 3);
      wait_done();
      chk("R9 verify length", vfy_len, V * (d + 1));
      rd(2, v);  chk("R9 verify fail bit", (v >> 3) & 1, 1);
      chk("R9 verify no hv", hv_rise - h0, 0);
      blank_ok = 1'b1;
      wr(5, 3);
      wait_done();
      rd(2, v);  chk("R9 verify pass bit", (v >> 3) & 1, 0);
    end

    do_reset();
    wr(0, 1);
    wr(3, 12'h123);
    wr(6, 16'hFFFF); wr(7, 16'hFFFF);
    rd(6, v);  chk("R10 reserved 6", v, 0);
    rd(7, v);  chk("R10 reserved 7", v, 0);
    rd(3, v);  chk("R10 addr untouched", v, 12'h123);
    rd(0, v);  chk("R10 divider untouched", v, 32'h8001);
    rd(2, v);  chk("R10 status untouched", v, 3);

    // same-row program pair, then a third command into a full queue
    h0 = hv_rise; p0 = pgm_rise;
    wr(3, 12'h100); wr(4, 1); wr(5, 1);
    wr(3, 12'h101); wr(4, 2); wr(5, 1);
    rd(2, v);  chk("R3 slot occupied", v & 3, 0);
    wr(5, 1);
    rd(2, v);  chk("R2 full cmd error", (v >> 2) & 1, 1);
    wait_done();
    chk("R3 third cmd dropped", pgm_rise - p0, 2);
    chk("R8 same row single ramp", hv_rise - h0, 1);
    chk("R8 same row hv span", hv_len, (R + 2 * P) * 2 + 1);
    chk("R11 second program data", pgm_data, 2);
    chk("R3 order last addr", pgm_addr, 12'h101);
    rd(2, v);  chk("R4 R3 idle status", v & 3, 3);
    wr(2, 4);

    // different rows
    h0 = hv_rise;
    wr(3, 12'h100); wr(5, 1);
    wr(3, 12'h200); wr(5, 1);
    wait_done();
    chk("R8 diff row re-ramp", hv_rise - h0, 2);
    chk("R8 diff row hv span", hv_len, (R + P) * 2);

    // program then erase on the same row
    h0 = hv_rise;
    wr(3, 12'h100); wr(5, 1); wr(5, 2);
    wait_done();
    chk("R8 prog-erase re-ramp", hv_rise - h0, 2);

    // invalid code
    p0 = pgm_rise;
    wr(5, 0);
    rd(2, v);  chk("R2 code zero error", (v >> 2) & 1, 1);
    chk("R2 code zero not run", pgm_rise - p0, 0);
    wr(2, 4);

    // interrupts
    wr(1, 0); @(negedge clk);
    chk("R5 masked", {30'd0, irq_empty, irq_done}, 0);
    wr(1, 1); @(negedge clk);
    chk("R5 empty irq", {30'd0, irq_empty, irq_done}, 2);
    wr(1, 3); @(negedge clk);
    chk("R5 both irq", {30'd0, irq_empty, irq_done}, 3);
    wr(3, 12'h010); wr(5, 1); wr(5, 1); @(negedge clk);
    chk("R5 busy full irq", {30'd0, irq_empty, irq_done}, 0);
    wait_done();
    @(negedge clk); @(negedge clk);
    chk("R5 done irq", {30'd0, irq_empty, irq_done}, 3);

    finish_run();
  end
endmodule